// File: doc/BRIEF.md
# I/Q Amplitude Bit Demodulator

This block turns a stream of signed 8-bit in-phase/quadrature correlation pairs into card-to-reader bits. Each bit period holds a window of 21 pairs. The first 5 pairs of the window are discarded. The next 8 are summed separately for the I and Q channels, and the last 8 are dropped. The two sums are reduced to an amplitude estimate: the larger magnitude plus half of the smaller one. The bit is a '1' when that amplitude divided by eight is strictly greater than a threshold.

A session begins with a start pulse that marks the end of the reader's own frame. The block waits a fixed delay, then takes one decision at the end of each fixed-length bit period. At every decision it pulses a keystream-advance strobe. The session runs in one of two modes:

- **Frame mode:** collects a programmed number of bits, XORs each with the keystream bit, and packs them LSB-first.
- **Acknowledge mode:** polls raw bits without XOR until a '1' arrives or a limit of periods runs out.

Top module: `iq_bit_demod`

## Requirements
- R1: After reset, `busy`, `done`, `ack`, `timeout`, `ks_adv` and `frame_data` are all 0.
- R2: Within a bit period, pairs with window index 0..4 and 13..20 do not affect the bit. Every valid pair after the 21st in the same period is also ignored.
- R3: Pairs with window index 5..12 are summed per channel as signed values without overflow. All eight at -128 gives a sum of -1024. The amplitude is max(|sumI|,|sumQ|) + floor(min(|sumI|,|sumQ|)/2).
- R4: The raw bit is 1 exactly when floor(amplitude/8) > 8, that is when the amplitude is at least 72.
- R5: A start accepted while idle is followed by decisions at 645 + 150·k cycles after the start edge. `ks_adv` is high for exactly one cycle ending at each decision edge, and at no other time.
- R6: In frame mode (`rx_mode`=0), bit k of the frame is the raw bit XOR the `ks_bit` value present at decision k. It is stored at `frame_data[k]`, and all bits above the frame length read 0. `done` is a one-cycle pulse that appears together with `busy` falling after the last decision.
- R7: In acknowledge mode (`rx_mode`=1), the raw bit is used without XOR. The session ends at the first decision whose raw bit is 1, with `ack`=1 and `timeout`=0. `ks_adv` pulses at every decision, and `frame_data` stays 0.
- R8: In acknowledge mode, if 60 decisions pass without a 1, `done` rises after the 60th decision with `ack`=0 and `timeout`=1.
- R9: `frame_len` values 1..32 give that many bits. The values 0 and 33..63 are taken as 32.
- R10: A `start` pulse while `busy` is 1 has no effect: the running session's timing, mode, length and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Marks the end of the reader frame; accepted only while idle |
| rx_mode | input | 1 | 0 = frame receive, 1 = acknowledge poll; latched at start |
| frame_len | input | 6 | Frame length in bits; latched at start |
| iq_valid | input | 1 | Qualifies one I/Q pair |
| iq_i | input | 8 | Signed in-phase sample |
| iq_q | input | 8 | Signed quadrature sample |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Keystream advance strobe, one per decision |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| ack | output | 1 | Acknowledge seen (acknowledge mode) |
| timeout | output | 1 | Acknowledge limit reached (acknowledge mode) |
| frame_data | output | 32 | Received frame, LSB first |

## Verification
The hardest conditions to reach are those where the slicer must ignore energy that is really on its input. These are large pairs placed in the skip and drop slices of the window, extra pairs after the 21st, and a second start pulse in the middle of a session. A single call to send one bit can surround a zero-energy middle with strong edge pairs, append surplus pairs in the idle tail, or fire a start pulse with a different mode and length part-way through the window. The amplitude threshold is approached from both sides using sums of 71 and 72 and mixed-sign I/Q pairs. The acknowledge limit is reached by sixty silent periods in a row.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BIT  = 2'd2
  } iqd_state_e;

  typedef enum logic {
    RX_FRAME = 1'b0,
    RX_ACK   = 1'b1
  } iqd_mode_e;

  localparam int IQD_CHANS = 2;

endpackage

// File: rtl/iqd_window_acc.sv
module iqd_window_acc #(
  parameter int SW   = 8,
  parameter int SKIP = 5,
  parameter int ACC  = 8,
  parameter int DROP = 8,
  parameter int AW   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_i,
  input  logic signed [SW-1:0] smp_q,
  output logic signed [AW-1:0] sum_i,
  output logic signed [AW-1:0] sum_q
);
  import iqd_pkg::*;

  localparam int WIN = SKIP + ACC + DROP;
  localparam int IW  = $clog2(WIN + 1);

  logic [IW-1:0] pair_idx;
  logic          take;
  logic          in_acc;

  assign take   = smp_valid && !clear && (pair_idx < IW'(WIN));
  assign in_acc = take && (pair_idx >= IW'(SKIP)) && (pair_idx < IW'(SKIP + ACC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pair_idx <= '0;
    else if (clear) pair_idx <= '0;
    else if (take)  pair_idx <= pair_idx + 1'b1;
  end

  // R2
  win_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_idx <= IW'(WIN));

  logic signed [AW-1:0] acc_q [IQD_CHANS];

  for (genvar ch = 0; ch < IQD_CHANS; ch++) begin : g_chan
    logic signed [SW-1:0] smp;
    assign smp = (ch == 0) ? smp_i : smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q[ch] <= '0;
      else if (clear)  acc_q[ch] <= '0;
      else if (in_acc) acc_q[ch] <= acc_q[ch] + {{(AW-SW){smp[SW-1]}}, smp};
    end

    // R3
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q[ch] >= -AW'(ACC * (2 ** (SW-1)))) && (acc_q[ch] <= AW'(ACC * (2 ** (SW-1) - 1))));
  end

  assign sum_i = acc_q[0];
  assign sum_q = acc_q[1];

endmodule

// File: rtl/iqd_slicer.sv
module iqd_slicer #(
  parameter int AW     = 12,
  parameter int SHIFT  = 3,
  parameter int THRESH = 8
) (
  input  logic signed [AW-1:0] sum_i,
  input  logic signed [AW-1:0] sum_q,
  output logic                 bit_one
);

  function automatic logic [AW-1:0] mag(input logic signed [AW-1:0] v);
    mag = v[AW-1] ? $unsigned(-v) : $unsigned(v);
  endfunction

  function automatic logic [AW-1:0] amp_est(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] hi, lo;
    hi = (a > b) ? a : b;
    lo = (a > b) ? b : a;
    amp_est = hi + (lo >> 1);
  endfunction

  logic [AW-1:0] mag_i, mag_q, amp;

  assign mag_i   = mag(sum_i);
  assign mag_q   = mag(sum_q);
  assign amp     = amp_est(mag_i, mag_q);
  assign bit_one = (amp >> SHIFT) > AW'(THRESH);

  // R3
  always_comb begin
    amp_bound_chk: assert ((amp >= mag_i) && (amp >= mag_q));
  end

endmodule

// File: rtl/iqd_seq.sv
module iqd_seq #(
  parameter int START_WAIT = 495,
  parameter int BIT_PERIOD = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic finish,
  output logic launch,
  output logic clear_win,
  output logic decide,
  output logic busy
);
  import iqd_pkg::*;

  localparam int MAXC = (START_WAIT > BIT_PERIOD) ? START_WAIT : BIT_PERIOD;
  localparam int CW   = $clog2(MAXC + 1);

  iqd_state_e    state;
  logic [CW-1:0] cnt;
  logic          wait_end;

  assign wait_end  = (state == ST_WAIT) && (cnt == CW'(START_WAIT - 1));
  assign decide    = (state == ST_BIT) && (cnt == CW'(BIT_PERIOD - 1));
  assign launch    = (state == ST_IDLE) && start;
  assign clear_win = wait_end || decide;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
        ST_WAIT: if (wait_end) begin
          state <= ST_BIT;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_BIT: if (decide) begin
          cnt <= '0;
          if (finish) state <= ST_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  dec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> !decide);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !decide) |=> busy);

  // R10
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && !launch));

endmodule

// File: rtl/iqd_collect.sv
module iqd_collect #(
  parameter int MAXLEN    = 32,
  parameter int ACK_LIMIT = 60,
  parameter int LW        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              mode_in,
  input  logic [LW-1:0]     len_in,
  input  logic              decide,
  input  logic              raw_bit,
  input  logic              ks_bit,
  output logic              finish,
  output logic [MAXLEN-1:0] frame_data,
  output logic              done,
  output logic              ack,
  output logic              timeout
);
  import iqd_pkg::*;

  localparam int CMAX = (MAXLEN > ACK_LIMIT) ? MAXLEN : ACK_LIMIT;
  localparam int CNTW = $clog2(CMAX + 1);

  iqd_mode_e       mode_q;
  logic [CNTW-1:0] last_q;
  logic [CNTW-1:0] bit_idx;
  logic [CNTW-1:0] last_in;
  logic            sliced;

  always_comb begin
    if ((len_in == '0) || (int'(len_in) > MAXLEN)) last_in = CNTW'(MAXLEN - 1);
    else                                           last_in = CNTW'(len_in) - 1'b1;
  end

  assign sliced = raw_bit ^ ks_bit;
  assign finish = decide && ((mode_q == RX_ACK) ? (raw_bit || (bit_idx == CNTW'(ACK_LIMIT - 1)))
                                                : (bit_idx == last_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= RX_FRAME;
      last_q  <= '0;
      bit_idx <= '0;
      done    <= 1'b0;
      ack     <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        mode_q  <= iqd_mode_e'(mode_in);
        last_q  <= last_in;
        bit_idx <= '0;
        ack     <= 1'b0;
        timeout <= 1'b0;
      end else if (decide) begin
        bit_idx <= bit_idx + 1'b1;
        if (finish) begin
          done <= 1'b1;
          if (mode_q == RX_ACK) begin
            ack     <= raw_bit;
            timeout <= !raw_bit;
          end
        end
      end
    end
  end

  for (genvar k = 0; k < MAXLEN; k++) begin : g_fbit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      frame_data[k] <= 1'b0;
      else if (launch) frame_data[k] <= 1'b0;
      else if (decide && (mode_q == RX_FRAME) && (bit_idx == CNTW'(k)))
        frame_data[k] <= sliced;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && timeout));

  // R7
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> done);

  // R9
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= CNTW'(CMAX));

endmodule

// File: rtl/iq_bit_demod.sv
module iq_bit_demod #(
  parameter int SW         = 8,
  parameter int SKIP       = 5,
  parameter int ACC        = 8,
  parameter int DROP       = 8,
  parameter int SHIFT      = 3,
  parameter int THRESH     = 8,
  parameter int START_WAIT = 495,
  parameter int BIT_PERIOD = 150,
  parameter int MAXLEN     = 32,
  parameter int ACK_LIMIT  = 60,
  parameter int LW         = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rx_mode,
  input  logic [LW-1:0]     frame_len,
  input  logic              iq_valid,
  input  logic [SW-1:0]     iq_i,
  input  logic [SW-1:0]     iq_q,
  input  logic              ks_bit,
  output logic              ks_adv,
  output logic              busy,
  output logic              done,
  output logic              ack,
  output logic              timeout,
  output logic [MAXLEN-1:0] frame_data
);

  localparam int AW = SW + $clog2(ACC) + 1;

  logic                 launch, clear_win, decide, finish, raw_bit;
  logic signed [AW-1:0] sum_i, sum_q;

  iqd_seq #(.START_WAIT(START_WAIT), .BIT_PERIOD(BIT_PERIOD)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .finish(finish),
    .launch(launch), .clear_win(clear_win), .decide(decide), .busy(busy)
  );

  iqd_window_acc #(.SW(SW), .SKIP(SKIP), .ACC(ACC), .DROP(DROP), .AW(AW)) win_i (
    .clk(clk), .rst_n(rst_n), .clear(clear_win), .smp_valid(iq_valid),
    .smp_i(iq_i), .smp_q(iq_q), .sum_i(sum_i), .sum_q(sum_q)
  );

  iqd_slicer #(.AW(AW), .SHIFT(SHIFT), .THRESH(THRESH)) slc_i (
    .sum_i(sum_i), .sum_q(sum_q), .bit_one(raw_bit)
  );

  iqd_collect #(.MAXLEN(MAXLEN), .ACK_LIMIT(ACK_LIMIT), .LW(LW)) col_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .mode_in(rx_mode), .len_in(frame_len),
    .decide(decide), .raw_bit(raw_bit), .ks_bit(ks_bit), .finish(finish),
    .frame_data(frame_data), .done(done), .ack(ack), .timeout(timeout)
  );

  assign ks_adv = decide;

  // R5
  ks_adv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv |-> busy);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: tb/iq_bit_demod_tb.sv
module iq_bit_demod_tb_top;

  localparam logic [31:0] KS_PAT = 32'hB5C3_96E1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rx_mode = 1'b0;
  logic [5:0]  frame_len = 6'd0;
  logic        iq_valid = 1'b0;
  logic [7:0]  iq_i = 8'd0;
  logic [7:0]  iq_q = 8'd0;
  logic        ks_bit;
  logic        ks_adv, busy, done, ack, timeout;
  logic [31:0] frame_data;

  always #2.5 clk = ~clk;

  iq_bit_demod dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_mode(rx_mode), .frame_len(frame_len),
    .iq_valid(iq_valid), .iq_i(iq_i), .iq_q(iq_q), .ks_bit(ks_bit), .ks_adv(ks_adv),
    .busy(busy), .done(done), .ack(ack), .timeout(timeout), .frame_data(frame_data)
  );

  int cyc = 0;
  int ks_idx = 0;
  assign ks_bit = KS_PAT[ks_idx % 32];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ks_adv) ks_idx <= ks_idx + 1;
  end

  typedef struct {
    logic [31:0] data;
    logic        ack;
    logic        tmo;
    int          cyc;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    adv_q[$];

  int    n_chk = 0, n_bad = 0;
  bit    finished = 0;
  int    c0, pred_idx = 0, pred_base, sess_bits;
  logic  sess_mode;
  logic [31:0] exp_data;
  string sess_tag;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic bit model_bit(input int si, input int sq);
    int a, b, hi, lo;
    a  = (si < 0) ? -si : si;
    b  = (sq < 0) ? -sq : sq;
    hi = (a > b) ? a : b;
    lo = (a > b) ? b : a;
    return (2 * hi + lo) >= 144;
  endfunction

  // Monitor: pops expected strobes and session results as they appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ks_adv) begin
        if (adv_q.size() == 0) check(0, "R5", "unexpected ks_adv at cycle", cyc, 0);
        else begin
          int e;
          e = adv_q.pop_front();
          check(cyc == e, "R5", "ks_adv cycle", cyc, e);
        end
      end
      if (done) begin
        if (exp_q.size() == 0) check(0, "R6", "unexpected done at cycle", cyc, 0);
        else begin
          exp_t  x;
          string t;
          x = exp_q.pop_front();
          t = tag_q.pop_front();
          check(frame_data == x.data, t, "frame_data", frame_data, x.data);
          check(ack == x.ack, t, "ack", ack, x.ack);
          check(timeout == x.tmo, t, "timeout", timeout, x.tmo);
          check(cyc == x.cyc, "R5", "done cycle", cyc, x.cyc);
          check(!busy, "R6", "busy with done", busy, 0);
        end
      end
    end
  end

  task automatic begin_session(input logic m, input logic [5:0] len, input string tag);
    @(negedge clk);
    start = 1'b1; rx_mode = m; frame_len = len;
    c0 = cyc; pred_base = pred_idx; sess_bits = 0; exp_data = '0;
    sess_mode = m; sess_tag = tag;
    @(negedge clk);
    start = 1'b0;
    repeat (496) @(negedge clk);
  endtask

  // Driver: one bit period of stimulus, expected items pushed ahead of time
  task automatic send_bit(input int mi, input int ml, input int mq, input int ei, input int eq,
                          input bit extra, input bit poke, input bit last);
    int si, sq;
    bit r;
    si = 7 * mi + ml;
    sq = 8 * mq;
    r  = model_bit(si, sq);
    if (!sess_mode) exp_data[sess_bits] = r ^ KS_PAT[(pred_base + sess_bits) % 32];
    adv_q.push_back(c0 + 645 + 150 * sess_bits);
    if (last) begin
      exp_t x;
      x.data = sess_mode ? 32'd0 : exp_data;
      x.ack  = sess_mode & r;
      x.tmo  = sess_mode & !r;
      x.cyc  = c0 + 646 + 150 * sess_bits;
      exp_q.push_back(x);
      tag_q.push_back(sess_tag);
      pred_idx = pred_base + sess_bits + 1;
    end
    sess_bits++;
    for (int p = 0; p < 21; p++) begin
      bit mid;
      mid = (p >= 5) && (p <= 12);
      iq_valid = 1'b1;
      iq_i = 8'(mid ? ((p == 12) ? ml : mi) : ei);
      iq_q = 8'(mid ? mq : eq);
      if (poke && p == 10) begin
        start = 1'b1; rx_mode = ~sess_mode; frame_len = 6'd3;
      end
      @(negedge clk);
      iq_valid = 1'b0; start = 1'b0;
      repeat (4) @(negedge clk);
    end
    if (extra) begin
      for (int p = 0; p < 3; p++) begin
        iq_valid = 1'b1; iq_i = 8'd120; iq_q = 8'd120;
        @(negedge clk);
        iq_valid = 1'b0;
        repeat (4) @(negedge clk);
      end
      repeat (30) @(negedge clk);
    end else begin
      repeat (45) @(negedge clk);
    end
  endtask

  task automatic bit_val(input bit v, input bit last);
    if (v) send_bit(20, 20, -15, 0, 0, 0, 0, last);
    else   send_bit(0, 0, 0, 0, 0, 0, 0, last);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0, "R1", "busy", busy, 0);
    check(done == 0, "R1", "done", done, 0);
    check(ack == 0, "R1", "ack", ack, 0);
    check(timeout == 0, "R1", "timeout", timeout, 0);
    check(ks_adv == 0, "R1", "ks_adv", ks_adv, 0);
    check(frame_data == 0, "R1", "frame_data", frame_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: 8-bit frame with keystream XOR
    begin_session(1'b0, 6'd8, "R6");
    for (int b = 0; b < 8; b++) bit_val((8'b0100_1101 >> b) & 1, b == 7);

    // R4 and R3: threshold boundaries, mixed signs, full-scale negative
    begin_session(1'b0, 6'd6, "R4");
    send_bit(9, 9, 0, 0, 0, 0, 0, 0);         // amp 72 -> 1
    send_bit(9, 8, 0, 0, 0, 0, 0, 0);         // amp 71 -> 0
    send_bit(-8, -8, 6, 0, 0, 0, 0, 0);       // 64 + 24 -> 1
    send_bit(-6, -6, 6, 0, 0, 0, 0, 0);       // 48 + 24 = 72 -> 1
    send_bit(-6, -6, 5, 0, 0, 0, 0, 0);       // 48 + 20 = 68 -> 0
    send_bit(-128, -128, -128, 0, 0, 0, 0, 1); // R3: sums -1024 -> 1

    // R2: energy in skip/drop slices and surplus pairs is ignored
    begin_session(1'b0, 6'd4, "R2");
    send_bit(0, 0, 0, 100, -100, 0, 0, 0);
    send_bit(0, 0, 0, 0, 0, 1, 0, 0);
    send_bit(20, 20, 0, -100, 100, 1, 0, 0);
    send_bit(0, 0, 0, 127, 127, 1, 0, 1);

    // R10 and R9: 32-bit frame with a start pulse while busy
    begin_session(1'b0, 6'd32, "R10");
    for (int b = 0; b < 32; b++) begin
      if (b == 1) send_bit(20, 20, -15, 0, 0, 0, 1, 0);
      else        bit_val(b % 3 == 0, b == 31);
    end

    // R9: length 0 taken as 32
    begin_session(1'b0, 6'd0, "R9");
    for (int b = 0; b < 32; b++) bit_val(b % 5 != 1, b == 31);

    // R9: length 1
    begin_session(1'b0, 6'd1, "R9");
    bit_val(1, 1);

    // R7: acknowledge after two silent periods
    begin_session(1'b1, 6'd5, "R7");
    bit_val(0, 0);
    bit_val(0, 0);
    bit_val(1, 1);

    // R8: acknowledge timeout after 60 silent periods
    begin_session(1'b1, 6'd5, "R8");
    for (int b = 0; b < 60; b++) bit_val(0, b == 59);

    // R7: immediate acknowledge
    begin_session(1'b1, 6'd2, "R7");
    bit_val(1, 1);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R6", "pending done items", exp_q.size(), 0);
    check(adv_q.size() == 0, "R5", "pending ks_adv items", adv_q.size(), 0);
    check(!busy, "R6", "busy at end", busy, 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule